// File: doc/BRIEF.md
# Test Access Port with FPGA Reconfiguration Request

This block is the serial test access port of a configuration-memory device. A board tester or a programming cable drives it over the usual four wires: test clock, mode select, data in and data out. A 16-state controller walks through instruction and data scans. Several data registers can sit between the data input and the data output: a one-bit bypass stage, a fixed 32-bit identification word, a 32-bit user word taken from an input, and a short boundary chain. The boundary chain can sample the pins or drive them in external test.

Two private instructions control an active-low, open-drain request line. That line goes to the configuration input of an attached FPGA. The restart instruction pulls the line low for as long as the controller rests in Run-Test/Idle, so the host can start a reconfiguration after programming. The hold instruction latches the line low through any later scans, which keeps the FPGA in reset while the flash is being written. Only a later restart instruction or a return to Test-Logic-Reset clears that latch. The block never drives the line high: it only asserts a pull-low enable, and a board resistor restores the level.

Top module: `tap_top`

## Requirements
- R1: After power-on reset, or after five consecutive TCK rising edges with TMS high from any state, the controller is in Test-Logic-Reset. The active instruction is then identification (10'h059), so a data scan taken straight after reset shifts out the identification word.
- R2: In Capture-IR the instruction shift register loads 10'b00_0000_0001, that is bit 0 = 1, bit 1 = 0 and the rest 0. An instruction scan shifts this value out LSB first.
- R3: Instruction 10'h059 selects the 32-bit identification register. It captures 0x0100A0DD, which is shifted out LSB first.
- R4: Instruction 10'h079 selects the 32-bit user register. It captures the `userCode` input, which is shifted out LSB first.
- R5: Instruction 10'h3FF selects the one-bit bypass stage. It captures 0, and each TDI bit appears on TDO one shift later.
- R6: Any opcode without an assignment (for example 10'h2AA), and the two private reconfiguration opcodes, behave as bypass.
- R7: Instruction 10'h055 (sample/preload) captures the boundary chain with `padIn` in bits [N_IN-1:0] and `coreOut` in bits [N_IN+N_OUT-1:N_IN], and shifts it out LSB first. While it is active, `padOut` follows `coreOut`.
- R8: Instruction 10'h000 (external test) drives `padOut` from the boundary update latch. The latch loads chain bits [N_IN+N_OUT-1:N_IN] at Update-DR.
- R9: With restart instruction 10'h061 active, `reconfDrvLow` is 1 in every cycle in which the controller is in Run-Test/Idle. It is 0 in the other states unless the hold latch is set.
- R10: After instruction 10'h065 reaches Update-IR, `reconfDrvLow` stays 1 in every state, across later scans of other instructions. It clears only when 10'h061 reaches Update-IR.
- R11: Entering Test-Logic-Reset clears the hold latch, so `reconfDrvLow` returns to 0.
- R12: TDO changes only on the falling edge of TCK. `tdoOe` is 1 only in the half-cycles that follow a falling edge in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdoOe | output | 1 | TDO output enable, high only while shifting |
| userCode | input | 32 | Value captured by the user register |
| padIn | input | N_IN | Device input pins seen by the boundary chain |
| coreOut | input | N_OUT | Functional values for the output pins |
| padOut | output | N_OUT | Values driven onto the output pins |
| reconfDrvLow | output | 1 | Pull-low enable of the open-drain reconfiguration request line |

## Verification
A wrong controller state shows up within one TCK edge. The request line then asserts or releases in the wrong state, or `tdoOe` opens outside a shift, and both are checked cycle by cycle against the TMS path the bench walks. A corrupted instruction or capture value shows up only at the end of the next scan, as a wrong serial word on TDO, so every instruction is paired with a full data scan. A hold latch that clears too early shows up on the request line during the scans that follow the hold instruction.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 10;

  localparam logic [IR_W-1:0] OP_EXTEST = 10'h000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 10'h055;
  localparam logic [IR_W-1:0] OP_IDCODE = 10'h059;
  localparam logic [IR_W-1:0] OP_USER   = 10'h079;
  localparam logic [IR_W-1:0] OP_RECONF = 10'h061;
  localparam logic [IR_W-1:0] OP_HOLD   = 10'h065;
  localparam logic [IR_W-1:0] OP_BYPASS = 10'h3FF;

  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};

  typedef enum logic [3:0] {
    ST_EX2_DR = 4'h0, ST_EX1_DR = 4'h1, ST_SH_DR  = 4'h2, ST_PA_DR  = 4'h3,
    ST_SEL_IR = 4'h4, ST_UPD_DR = 4'h5, ST_CAP_DR = 4'h6, ST_SEL_DR = 4'h7,
    ST_EX2_IR = 4'h8, ST_EX1_IR = 4'h9, ST_SH_IR  = 4'hA, ST_PA_IR  = 4'hB,
    ST_RTI    = 4'hC, ST_UPD_IR = 4'hD, ST_CAP_IR = 4'hE, ST_TLR    = 4'hF
  } tapState_e;

  typedef enum logic [1:0] {
    SEL_BYPASS, SEL_IDENT, SEL_USER, SEL_BOUND
  } drSel_e;

  typedef struct packed {
    logic   captureIr;
    logic   shiftIr;
    logic   captureDr;
    logic   shiftDr;
    logic   updateDr;
    logic   shiftAny;
    logic   extestOn;
    drSel_e sel;
  } tapStrobe_t;

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            porRstN,
  input  logic            tms,
  input  logic [IR_W-1:0] irShift,
  output tapState_e       state,
  output logic [IR_W-1:0] instr,
  output tapStrobe_t      strb,
  output logic            holdQ,
  output logic            reconfDrvLow
);

  tapState_e nextState;

  always_comb begin
    unique case (state)
      ST_TLR:    nextState = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nextState = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nextState = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nextState = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nextState = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_RTI;
      default:   nextState = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge porRstN) begin
    if (!porRstN) state <= ST_TLR;
    else          state <= nextState;
  end

  // instruction register: loaded on the edge that leaves Update-IR
  always_ff @(posedge tck or negedge porRstN) begin
    if (!porRstN)               instr <= OP_IDCODE;
    else if (state == ST_TLR)   instr <= OP_IDCODE;
    else if (state == ST_UPD_IR) instr <= irShift;
  end

  // hold latch for the reconfiguration request
  always_ff @(posedge tck or negedge porRstN) begin
    if (!porRstN) holdQ <= 1'b0;
    else if (state == ST_TLR) holdQ <= 1'b0;
    else if (state == ST_UPD_IR) begin
      if (irShift == OP_HOLD)        holdQ <= 1'b1;
      else if (irShift == OP_RECONF) holdQ <= 1'b0;
    end
  end

  assign reconfDrvLow = holdQ || ((instr == OP_RECONF) && (state == ST_RTI));

  always_comb begin
    strb.captureIr = (state == ST_CAP_IR);
    strb.shiftIr   = (state == ST_SH_IR);
    strb.captureDr = (state == ST_CAP_DR);
    strb.shiftDr   = (state == ST_SH_DR);
    strb.updateDr  = (state == ST_UPD_DR);
    strb.shiftAny  = (state == ST_SH_IR) || (state == ST_SH_DR);
    strb.extestOn  = (instr == OP_EXTEST);
    unique case (instr)
      OP_IDCODE:            strb.sel = SEL_IDENT;
      OP_USER:              strb.sel = SEL_USER;
      OP_SAMPLE, OP_EXTEST: strb.sel = SEL_BOUND;
      default:              strb.sel = SEL_BYPASS;
    endcase
  end

endmodule

// File: rtl/tap_datapath.sv
module tap_datapath
  import tap_pkg::*;
#(
  parameter int          N_IN     = 2,
  parameter int          N_OUT    = 2,
  parameter int          CODE_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h0100A0DD
) (
  input  logic              tck,
  input  logic              porRstN,
  input  logic              tdi,
  input  tapStrobe_t        strb,
  input  logic [CODE_W-1:0] userCode,
  input  logic [N_IN-1:0]   padIn,
  input  logic [N_OUT-1:0]  coreOut,
  output logic [N_OUT-1:0]  padOut,
  output logic [IR_W-1:0]   irShift,
  output logic              tdo,
  output logic              tdoOe
);

  localparam int BS_W = N_IN + N_OUT;

  logic              bypassQ;
  logic [CODE_W-1:0] identSr;
  logic [CODE_W-1:0] userSr;
  logic [BS_W-1:0]   bsSr;
  logic [N_OUT-1:0]  bsUpd;
  logic              serialBit;

  always_ff @(posedge tck or negedge porRstN) begin
    if (!porRstN)            irShift <= '0;
    else if (strb.captureIr) irShift <= IR_CAPTURE;
    else if (strb.shiftIr)   irShift <= {tdi, irShift[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge porRstN) begin
    if (!porRstN) begin
      bypassQ <= 1'b0;
      identSr <= '0;
      userSr  <= '0;
      bsSr    <= '0;
    end else if (strb.captureDr) begin
      unique case (strb.sel)
        SEL_IDENT: identSr <= ID_VALUE[CODE_W-1:0];
        SEL_USER:  userSr  <= userCode;
        SEL_BOUND: bsSr    <= {coreOut, padIn};
        default:   bypassQ <= 1'b0;
      endcase
    end else if (strb.shiftDr) begin
      unique case (strb.sel)
        SEL_IDENT: identSr <= {tdi, identSr[CODE_W-1:1]};
        SEL_USER:  userSr  <= {tdi, userSr[CODE_W-1:1]};
        SEL_BOUND: bsSr    <= {tdi, bsSr[BS_W-1:1]};
        default:   bypassQ <= tdi;
      endcase
    end
  end

  always_ff @(posedge tck or negedge porRstN) begin
    if (!porRstN) bsUpd <= '0;
    else if (strb.updateDr && (strb.sel == SEL_BOUND)) bsUpd <= bsSr[BS_W-1:N_IN];
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_outCell
      assign padOut[gi] = strb.extestOn ? bsUpd[gi] : coreOut[gi];
    end
  endgenerate

  always_comb begin
    if (strb.shiftIr) serialBit = irShift[0];
    else begin
      unique case (strb.sel)
        SEL_IDENT: serialBit = identSr[0];
        SEL_USER:  serialBit = userSr[0];
        SEL_BOUND: serialBit = bsSr[0];
        default:   serialBit = bypassQ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge porRstN) begin
    if (!porRstN) begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end else begin
      tdo   <= serialBit;
      tdoOe <= strb.shiftAny;
    end
  end

endmodule

// File: rtl/tap_top.sv
module tap_top
  import tap_pkg::*;
#(
  parameter int          N_IN     = 2,
  parameter int          N_OUT    = 2,
  parameter logic [31:0] ID_VALUE = 32'h0100A0DD
) (
  input  logic             tck,
  input  logic             porRstN,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdoOe,
  input  logic [31:0]      userCode,
  input  logic [N_IN-1:0]  padIn,
  input  logic [N_OUT-1:0] coreOut,
  output logic [N_OUT-1:0] padOut,
  output logic             reconfDrvLow
);

  tapState_e       tapState;
  logic [IR_W-1:0] curInstr;
  logic [IR_W-1:0] irShift;
  tapStrobe_t      strb;
  logic            holdQ;

  tap_ctrl u_ctrl (
    .tck          (tck),
    .porRstN      (porRstN),
    .tms          (tms),
    .irShift      (irShift),
    .state        (tapState),
    .instr        (curInstr),
    .strb         (strb),
    .holdQ        (holdQ),
    .reconfDrvLow (reconfDrvLow)
  );

  tap_datapath #(
    .N_IN     (N_IN),
    .N_OUT    (N_OUT),
    .CODE_W   (32),
    .ID_VALUE (ID_VALUE)
  ) u_dp (
    .tck      (tck),
    .porRstN  (porRstN),
    .tdi      (tdi),
    .strb     (strb),
    .userCode (userCode),
    .padIn    (padIn),
    .coreOut  (coreOut),
    .padOut   (padOut),
    .irShift  (irShift),
    .tdo      (tdo),
    .tdoOe    (tdoOe)
  );

endmodule

// File: rtl/tap_checker.sv
module tap_checker
  import tap_pkg::*;
(
  input logic            tck,
  input logic            porRstN,
  input logic            tms,
  input tapState_e       state,
  input logic [IR_W-1:0] instr,
  input logic            holdQ,
  input logic            reconfDrvLow,
  input logic            tdoOe
);

  logic [2:0] tmsRun;

  always_ff @(posedge tck or negedge porRstN) begin
    if (!porRstN)          tmsRun <= '0;
    else if (!tms)         tmsRun <= '0;
    else if (tmsRun != 3'd7) tmsRun <= tmsRun + 3'd1;
  end

  p_five_tms_tlr_r1: assert property (@(posedge tck) disable iff (!porRstN)
    (tmsRun >= 3'd5) |-> (state == ST_TLR));

  p_tlr_loads_id_r1: assert property (@(posedge tck) disable iff (!porRstN)
    (state == ST_TLR) |=> (instr == OP_IDCODE));

  p_tlr_clears_hold_r11: assert property (@(posedge tck) disable iff (!porRstN)
    (state == ST_TLR) |=> !holdQ);

  p_oe_shift_only_r12: assert property (@(posedge tck) disable iff (!porRstN)
    tdoOe == ((state == ST_SH_DR) || (state == ST_SH_IR)));

  p_reconf_in_idle_r9: assert property (@(posedge tck) disable iff (!porRstN)
    ((instr == OP_RECONF) && (state == ST_RTI)) |-> reconfDrvLow);

  p_reconf_released_r9: assert property (@(posedge tck) disable iff (!porRstN)
    (!holdQ && (state != ST_RTI)) |-> !reconfDrvLow);

  p_hold_drives_r10: assert property (@(posedge tck) disable iff (!porRstN)
    holdQ |-> reconfDrvLow);

  p_hold_set_by_update_r10: assert property (@(posedge tck) disable iff (!porRstN)
    $rose(holdQ) |-> ($past(state) == ST_UPD_IR));

endmodule

bind tap_top tap_checker u_chk (
  .tck          (tck),
  .porRstN      (porRstN),
  .tms          (tms),
  .state        (tapState),
  .instr        (curInstr),
  .holdQ        (holdQ),
  .reconfDrvLow (reconfDrvLow),
  .tdoOe        (tdoOe)
);

// File: tb/sim_tap_top.sv
`timescale 1ns/1ps
module sim_tap_top;

  localparam int N_IN  = 2;
  localparam int N_OUT = 2;

  logic tck = 1'b0;
  logic porRstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdoOe, reconfDrvLow;
  logic [31:0] userCode = 32'hCAFE1234;
  logic [N_IN-1:0] padIn = 2'b10;
  logic [N_OUT-1:0] coreOut = 2'b01;
  logic [N_OUT-1:0] padOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  tap_top #(.N_IN(N_IN), .N_OUT(N_OUT)) u0 (
    .tck(tck), .porRstN(porRstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoOe(tdoOe),
    .userCode(userCode), .padIn(padIn), .coreOut(coreOut), .padOut(padOut),
    .reconfDrvLow(reconfDrvLow)
  );

  typedef struct packed {
    logic [9:0]  op;
    logic [5:0]  len;
    logic [31:0] din;
    logic [31:0] exp;
  } vec_t;

  // R3 identification, R4 user word, R5 bypass, R6 unassigned, R7 sample capture
  localparam vec_t VECS [5] = '{
    '{10'h059, 6'd32, 32'h0000_0000, 32'h0100A0DD},
    '{10'h079, 6'd32, 32'h1111_2222, 32'hCAFE1234},
    '{10'h3FF, 6'd8,  32'h0000_00A5, 32'h0000_004A},
    '{10'h2AA, 6'd8,  32'h0000_003C, 32'h0000_0078},
    '{10'h055, 6'd4,  32'h0000_0000, 32'h0000_0006}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic sampled);
    @(negedge tck); #1;
    sampled = tdo;
    tms = m;
    tdi = d;
    @(posedge tck);
  endtask

  task automatic tapReset();
    logic s;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, s);
    step(1'b0, 1'b0, s);
  endtask

  // from Run-Test/Idle to Run-Test/Idle
  task automatic scanIr(input logic [9:0] code, output logic [9:0] dout);
    logic s;
    step(1'b1, 1'b0, s); step(1'b1, 1'b0, s);
    step(1'b0, 1'b0, s); step(1'b0, 1'b0, s);
    for (int i = 0; i < 10; i++) begin
      step(i == 9, code[i], s);
      dout[i] = s;
    end
    step(1'b1, 1'b0, s); step(1'b0, 1'b0, s);
  endtask

  task automatic scanDr(input logic [31:0] din, input int len, output logic [31:0] dout);
    logic s;
    dout = '0;
    step(1'b1, 1'b0, s); step(1'b0, 1'b0, s); step(1'b0, 1'b0, s);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i], s);
      dout[i] = s;
    end
    step(1'b1, 1'b0, s); step(1'b0, 1'b0, s);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [9:0] irOut;
    logic [31:0] drOut;
    logic s;

    repeat (3) @(posedge tck);
    #1;
    chk("R1 reset tdoOe", {31'b0, tdoOe}, 32'h0);
    chk("R1 reset request line", {31'b0, reconfDrvLow}, 32'h0);
    porRstN = 1'b1;
    tapReset();

    // R1: identification active straight after reset
    scanDr(32'h0, 32, drOut);
    chk("R1 id after reset", drOut, 32'h0100A0DD);

    // R2 capture pattern of the instruction register
    scanIr(10'h059, irOut);
    chk("R2 ir capture", {22'b0, irOut}, 32'h001);

    foreach (VECS[k]) begin
      scanIr(VECS[k].op, irOut);
      scanDr(VECS[k].din, int'(VECS[k].len), drOut);
      chk($sformatf("R3-R7 vector %0d", k), drOut, VECS[k].exp);
    end

    // R7: sample keeps the functional path
    chk("R7 sample padOut", {30'b0, padOut}, {30'b0, coreOut});

    // R8 external test
    scanIr(10'h000, irOut);
    scanDr(32'hB, 4, drOut);
    #1;
    chk("R8 extest padOut", {30'b0, padOut}, 32'h2);

    // R9 restart request in idle
    scanIr(10'h061, irOut);
    #1;
    chk("R9 low in idle", {31'b0, reconfDrvLow}, 32'h1);
    step(1'b1, 1'b0, s); #1;
    chk("R9 released outside idle", {31'b0, reconfDrvLow}, 32'h0);
    step(1'b1, 1'b0, s); step(1'b0, 1'b0, s); step(1'b0, 1'b0, s);
    for (int i = 0; i < 10; i++) step(i == 9, 1'b0, s);
    step(1'b1, 1'b0, s); step(1'b0, 1'b0, s);

    // R10 hold persists across other scans
    scanIr(10'h065, irOut);
    step(1'b1, 1'b0, s); #1;
    chk("R10 hold outside idle", {31'b0, reconfDrvLow}, 32'h1);
    step(1'b1, 1'b0, s); step(1'b0, 1'b0, s); step(1'b0, 1'b0, s);
    for (int i = 0; i < 10; i++) step(i == 9, 1'b1, s);
    step(1'b1, 1'b0, s); step(1'b0, 1'b0, s);
    scanDr(32'h5, 4, drOut);
    step(1'b1, 1'b0, s); #1;
    chk("R10 hold after bypass scan", {31'b0, reconfDrvLow}, 32'h1);
    step(1'b1, 1'b0, s); step(1'b0, 1'b0, s); step(1'b0, 1'b0, s);
    for (int i = 0; i < 10; i++) step(i == 9, (10'h061 >> i) & 1'b1, s);
    step(1'b1, 1'b0, s); step(1'b0, 1'b0, s);
    step(1'b1, 1'b0, s); #1;
    chk("R10 hold cleared by restart", {31'b0, reconfDrvLow}, 32'h0);
    step(1'b0, 1'b0, s); step(1'b1, 1'b0, s); step(1'b1, 1'b0, s); step(1'b0, 1'b0, s);

    // R11 reset clears hold
    scanIr(10'h065, irOut);
    tapReset();
    step(1'b1, 1'b0, s); #1;
    chk("R11 reset clears hold", {31'b0, reconfDrvLow}, 32'h0);
    step(1'b1, 1'b0, s); step(1'b1, 1'b0, s); step(1'b0, 1'b0, s);

    // R12 TDO timing: falling edge updates only
    step(1'b1, 1'b0, s); step(1'b0, 1'b0, s); step(1'b0, 1'b0, s);
    #1;
    chk("R12 oe off before first fall", {31'b0, tdoOe}, 32'h0);
    @(negedge tck); #1;
    chk("R12 oe on in shift", {31'b0, tdoOe}, 32'h1);
    chk("R12 first id bit", {31'b0, tdo}, 32'h1);
    @(posedge tck); #1;
    chk("R12 tdo holds over rise", {31'b0, tdo}, 32'h1);
    @(negedge tck); #1;
    chk("R12 second id bit", {31'b0, tdo}, 32'h0);
    tms = 1'b1;
    @(posedge tck);
    step(1'b1, 1'b0, s); step(1'b0, 1'b0, s);
    @(negedge tck); #1;
    chk("R12 oe off in idle", {31'b0, tdoOe}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule